// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit sits next to a small processor core and watches its buses while user code runs. It holds six 16-bit breakpoint values. Four of them are compared only against the address of each fetched instruction. The other two can each be switched between two sources: the data memory address of a load or store, or the identifier of a register being accessed. When matching is armed and any breakpoint hits, the unit sends the core a one-cycle break request and enters debug mode. It also records which breakpoints caused the break.

Only the debug host can reach the breakpoint values, the control word and the status word, and only while its background-mode signal is high. Software running on the core has no path to them. A resume command from the host leaves debug mode and clears the status, so matching starts again. The reset input is asynchronous. Inside the unit it is released in step with the clock through a two-stage synchronizer.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset all six breakpoint values read 0xFFFF. The control word and the status word read 0, and `dbg_mode` is 0.
- R2: The host register map has addresses 0 to 5 for breakpoints 0 to 5. Address 6 is the control word: bit 0 arms matching, bit 1 sets the mode of breakpoint 4, and bit 2 sets the mode of breakpoint 5. Address 7 is the status word, bits 5:0, and it is read-only. Reads return the value when `host_bg_mode` and `host_rd` are both high, and 0 otherwise.
- R3: A write with `host_bg_mode` low changes no register.
- R4: Breakpoints 0 to 3 hit when `fetch_vld` is high and `fetch_addr` equals their value.
- R5: When its mode bit is 0, breakpoint 4 or 5 hits on `dmem_rd` or `dmem_wr` with a matching `dmem_addr`. When its mode bit is 1, it hits on `reg_acc_vld` with a matching `reg_acc_id`, and data accesses are ignored.
- R6: A hit raises a break only while the unit is armed, `cpu_user_run` is high and `dbg_mode` is 0.
- R7: `break_pulse` is high for exactly the one cycle after the matching cycle. `dbg_mode` rises at the same edge.
- R8: While `dbg_mode` is high no further break is raised. A `host_resume` with `host_bg_mode` high clears `dbg_mode` and the status at the next edge.
- R9: On a break, status bit i is set for every breakpoint i that hit in that cycle. The status then holds until resume.
- R10: A bus value whose qualifying strobe is low never causes a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_bg_mode | input | 1 | Host background mode is active |
| host_wr | input | 1 | Host register write |
| host_rd | input | 1 | Host register read |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_resume | input | 1 | Host command to leave debug mode |
| cpu_user_run | input | 1 | Core is executing user code |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 16 | Instruction fetch address |
| dmem_rd | input | 1 | Data memory read strobe |
| dmem_wr | input | 1 | Data memory write strobe |
| dmem_addr | input | 16 | Data memory address |
| reg_acc_vld | input | 1 | Register access strobe |
| reg_acc_id | input | 16 | Accessed register identifier |
| break_pulse | output | 1 | One-cycle break request to the core |
| dbg_mode | output | 1 | Unit is in debug mode |
| brk_status | output | 6 | Breakpoints that caused the last break |

## Verification
The hardest case to reach is several breakpoints of different kinds hitting in the same cycle. A fetch match has to land on the same edge as a data or register-access match, while the unit is armed and out of debug mode. The directed part of the bench programs distinct values and then drives a fetch and a data read together. A random phase follows. It draws addresses from a small pool that overlaps the programmed values, and it mixes in host writes, mode flips and resumes. Each cycle the outputs are compared against a behavioural model.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  // Source selection for the switchable breakpoints
  typedef enum logic {
    FLEX_DATA_ADDR = 1'b0,
    FLEX_REG_ID    = 1'b1
  } flex_mode_e;
endpackage

// File: rtl/bkpt_regs.sv
// Host-visible storage: breakpoint values, control word, status read-back (R1, R2, R3)
module bkpt_regs #(
  parameter int W     = 16,
  parameter int NPROG = 4,
  parameter int NFLEX = 2,
  parameter int AW    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_bg_mode,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [AW-1:0]          host_addr,
  input  logic [W-1:0]           host_wdata,
  input  logic [NPROG+NFLEX-1:0] status,
  output logic [(NPROG+NFLEX)*W-1:0] bp_flat,
  output logic                   armed,
  output logic [NFLEX-1:0]       flex_mode,
  output logic [W-1:0]           host_rdata
);
  localparam int NBP = NPROG + NFLEX;
  localparam int CW  = NFLEX + 1;
  localparam logic [AW-1:0] CTRL_A = AW'(NBP);
  localparam logic [AW-1:0] STAT_A = AW'(NBP + 1);

  logic           wr_ok;
  logic [W-1:0]   bp_q  [NBP];
  logic [NBP-1:0] bp_we;
  logic [CW-1:0]  ctrl_q, ctrl_d;
  logic           ctrl_we;

  assign wr_ok = host_bg_mode && host_wr;

  always_comb begin
    for (int i = 0; i < NBP; i++) begin
      bp_we[i] = wr_ok && (host_addr == AW'(i));
    end
    ctrl_we = wr_ok && (host_addr == CTRL_A);
    ctrl_d  = host_wdata[CW-1:0];
  end

  for (genvar i = 0; i < NBP; i++) begin : g_bp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bp_q[i] <= '1;
      end else if (bp_we[i]) begin
        bp_q[i] <= host_wdata;
      end
    end
    assign bp_flat[i*W +: W] = bp_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign armed     = ctrl_q[0];
  assign flex_mode = ctrl_q[CW-1:1];

  always_comb begin
    host_rdata = '0;
    if (host_bg_mode && host_rd) begin
      if (int'(host_addr) < NBP) begin
        host_rdata = bp_q[host_addr];
      end else if (host_addr == CTRL_A) begin
        host_rdata = W'(ctrl_q);
      end else if (host_addr == STAT_A) begin
        host_rdata = W'(status);
      end
    end
  end
endmodule

// File: rtl/bkpt_cmp.sv
// One comparator; FLEX selects the switchable variant (R4, R5, R10)
module bkpt_cmp import bkpt_pkg::*; #(
  parameter int W    = 16,
  parameter bit FLEX = 1'b0
) (
  input  logic         fetch_vld,
  input  logic [W-1:0] fetch_addr,
  input  logic         daddr_vld,
  input  logic [W-1:0] daddr,
  input  logic         rid_vld,
  input  logic [W-1:0] rid,
  input  logic [W-1:0] bp_val,
  input  logic         mode,
  output logic         hit
);
  logic use_rid;
  logic fetch_hit, data_hit, rid_hit;

  always_comb begin
    use_rid   = FLEX && (flex_mode_e'(mode) == FLEX_REG_ID);
    fetch_hit = !FLEX && fetch_vld && (fetch_addr == bp_val);
    data_hit  = FLEX && !use_rid && daddr_vld && (daddr == bp_val);
    rid_hit   = use_rid && rid_vld && (rid == bp_val);
    hit       = fetch_hit || data_hit || rid_hit;
  end
endmodule

// File: rtl/bkpt_ctrl.sv
// Break generation, debug flag and cause capture (R6, R7, R8, R9)
module bkpt_ctrl #(
  parameter int NBP = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NBP-1:0] hits,
  input  logic           armed,
  input  logic           user_run,
  input  logic           resume,
  output logic           break_pulse,
  output logic           dbg_mode,
  output logic [NBP-1:0] status
);
  logic           fire;
  logic           pulse_d, dbg_d;
  logic [NBP-1:0] stat_d;

  always_comb begin
    fire    = armed && user_run && !dbg_mode && (|hits);
    pulse_d = fire;
    dbg_d   = dbg_mode;
    stat_d  = status;
    if (fire) begin
      dbg_d  = 1'b1;
      stat_d = hits;
    end else if (resume) begin
      dbg_d  = 1'b0;
      stat_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      break_pulse <= 1'b0;
      dbg_mode    <= 1'b0;
      status      <= '0;
    end else begin
      break_pulse <= pulse_d;
      dbg_mode    <= dbg_d;
      status      <= stat_d;
    end
  end
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit #(
  parameter int W     = 16,
  parameter int NPROG = 4,
  parameter int NFLEX = 2,
  parameter int AW    = $clog2(NPROG + NFLEX + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_bg_mode,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [AW-1:0]          host_addr,
  input  logic [W-1:0]           host_wdata,
  output logic [W-1:0]           host_rdata,
  input  logic                   host_resume,
  input  logic                   cpu_user_run,
  input  logic                   fetch_vld,
  input  logic [W-1:0]           fetch_addr,
  input  logic                   dmem_rd,
  input  logic                   dmem_wr,
  input  logic [W-1:0]           dmem_addr,
  input  logic                   reg_acc_vld,
  input  logic [W-1:0]           reg_acc_id,
  output logic                   break_pulse,
  output logic                   dbg_mode,
  output logic [NPROG+NFLEX-1:0] brk_status
);
  localparam int NBP = NPROG + NFLEX;

  logic                srst_n;
  logic [1:0]          sync_q;
  logic [NBP*W-1:0]    bp_flat;
  logic                armed;
  logic [NFLEX-1:0]    flex_mode;
  logic [NBP-1:0]      hits;
  logic                daddr_vld;
  logic                resume;

  // Asynchronous assertion, clocked release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end
  assign srst_n = sync_q[1];

  assign daddr_vld = dmem_rd || dmem_wr;
  assign resume    = host_bg_mode && host_resume;

  bkpt_regs #(.W(W), .NPROG(NPROG), .NFLEX(NFLEX), .AW(AW)) u_regs (
    .clk          (clk),
    .rst_n        (srst_n),
    .host_bg_mode (host_bg_mode),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .status       (brk_status),
    .bp_flat      (bp_flat),
    .armed        (armed),
    .flex_mode    (flex_mode),
    .host_rdata   (host_rdata)
  );

  for (genvar i = 0; i < NBP; i++) begin : g_cmp
    if (i < NPROG) begin : g_prog
      bkpt_cmp #(.W(W), .FLEX(1'b0)) u_cmp (
        .fetch_vld  (fetch_vld),
        .fetch_addr (fetch_addr),
        .daddr_vld  (daddr_vld),
        .daddr      (dmem_addr),
        .rid_vld    (reg_acc_vld),
        .rid        (reg_acc_id),
        .bp_val     (bp_flat[i*W +: W]),
        .mode       (1'b0),
        .hit        (hits[i])
      );
    end else begin : g_flex
      bkpt_cmp #(.W(W), .FLEX(1'b1)) u_cmp (
        .fetch_vld  (fetch_vld),
        .fetch_addr (fetch_addr),
        .daddr_vld  (daddr_vld),
        .daddr      (dmem_addr),
        .rid_vld    (reg_acc_vld),
        .rid        (reg_acc_id),
        .bp_val     (bp_flat[i*W +: W]),
        .mode       (flex_mode[i-NPROG]),
        .hit        (hits[i])
      );
    end
  end

  bkpt_ctrl #(.NBP(NBP)) u_ctrl (
    .clk         (clk),
    .rst_n       (srst_n),
    .hits        (hits),
    .armed       (armed),
    .user_run    (cpu_user_run),
    .resume      (resume),
    .break_pulse (break_pulse),
    .dbg_mode    (dbg_mode),
    .status      (brk_status)
  );
endmodule

// File: rtl/bkpt_match_chk.sv
module bkpt_match_chk #(
  parameter int NBP = 6,
  parameter int W   = 16
) (
  input logic           clk,
  input logic           srst_n,
  input logic           host_bg_mode,
  input logic           cpu_user_run,
  input logic           armed,
  input logic [NBP*W-1:0] bp_flat,
  input logic           break_pulse,
  input logic           dbg_mode,
  input logic [NBP-1:0] brk_status
);
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!srst_n)
    break_pulse |=> !break_pulse);

  assert_pulse_enters_debug_R7: assert property (@(posedge clk) disable iff (!srst_n)
    break_pulse |-> dbg_mode);

  assert_pulse_has_cause_R9: assert property (@(posedge clk) disable iff (!srst_n)
    break_pulse |-> (brk_status != '0));

  assert_break_gated_R6: assert property (@(posedge clk) disable iff (!srst_n)
    break_pulse |-> ($past(armed) && $past(cpu_user_run) && !$past(dbg_mode)));

  assert_no_fg_write_R3: assert property (@(posedge clk) disable iff (!srst_n)
    !host_bg_mode |=> $stable(bp_flat));

  assert_resume_clears_R8: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(dbg_mode) |-> (brk_status == '0));

  assert_status_held_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (dbg_mode && $past(dbg_mode)) |-> $stable(brk_status));
endmodule

bind bkpt_match_unit bkpt_match_chk #(.NBP(NPROG + NFLEX), .W(W)) u_chk (
  .clk          (clk),
  .srst_n       (srst_n),
  .host_bg_mode (host_bg_mode),
  .cpu_user_run (cpu_user_run),
  .armed        (armed),
  .bp_flat      (bp_flat),
  .break_pulse  (break_pulse),
  .dbg_mode     (dbg_mode),
  .brk_status   (brk_status)
);

// File: tb/sim_bkpt_match_unit.sv
`timescale 1ns/100ps
module sim_bkpt_match_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_bg_mode, host_wr, host_rd, host_resume;
  logic [2:0]  host_addr;
  logic [15:0] host_wdata, host_rdata;
  logic        cpu_user_run, fetch_vld, dmem_rd, dmem_wr, reg_acc_vld;
  logic [15:0] fetch_addr, dmem_addr, reg_acc_id;
  logic        break_pulse, dbg_mode;
  logic [5:0]  brk_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bkpt_match_unit u0 (.*);

  // ---------------- behavioural reference ----------------
  int m_bp [6];
  int m_mode [2];
  int m_en, m_dbg, m_stat, m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_bp[k]) m_bp[k] = 16'hFFFF;
      m_mode[0] = 0; m_mode[1] = 0;
      m_en = 0; m_dbg = 0; m_stat = 0; m_pulse = 0;
    end else begin
      int hits;
      hits = 0;
      for (int k = 0; k < 4; k++)
        if (fetch_vld && fetch_addr == m_bp[k]) hits |= (1 << k);
      for (int k = 0; k < 2; k++) begin
        if (m_mode[k] == 0 && (dmem_rd || dmem_wr) && dmem_addr == m_bp[4+k]) hits |= (1 << (4+k));
        if (m_mode[k] == 1 && reg_acc_vld && reg_acc_id == m_bp[4+k]) hits |= (1 << (4+k));
      end
      if (m_en && cpu_user_run && !m_dbg && hits != 0) begin
        m_pulse = 1; m_dbg = 1; m_stat = hits;
      end else begin
        m_pulse = 0;
        if (host_bg_mode && host_resume) begin m_dbg = 0; m_stat = 0; end
      end
      if (host_bg_mode && host_wr) begin
        if (host_addr < 6) m_bp[host_addr] = host_wdata;
        else if (host_addr == 6) begin
          m_en = host_wdata[0]; m_mode[0] = host_wdata[1]; m_mode[1] = host_wdata[2];
        end
      end
    end
  end

  function automatic int exp_rdata();
    if (!(host_bg_mode && host_rd)) return 0;
    if (host_addr < 6) return m_bp[host_addr];
    if (host_addr == 6) return m_en | (m_mode[0] << 1) | (m_mode[1] << 2);
    return m_stat;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 break_pulse vs model", int'(break_pulse), m_pulse);
      chk("R8 dbg_mode vs model", int'(dbg_mode), m_dbg);
      chk("R9 brk_status vs model", int'(brk_status), m_stat);
      chk("R2 host_rdata vs model", int'(host_rdata), exp_rdata());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    host_bg_mode = 0; host_wr = 0; host_rd = 0; host_resume = 0;
    host_addr = 0; host_wdata = 0;
    fetch_vld = 0; dmem_rd = 0; dmem_wr = 0; reg_acc_vld = 0;
  endtask

  task automatic hwrite(input int a, input int d, input bit bg);
    host_bg_mode = bg; host_wr = 1; host_addr = 3'(a); host_wdata = 16'(d);
    cyc();
    host_wr = 0; host_bg_mode = 0;
  endtask

  task automatic hread(input int a, input int exp, input bit bg, input string tag);
    host_bg_mode = bg; host_rd = 1; host_addr = 3'(a);
    #0.5;
    chk(tag, int'(host_rdata), exp);
    cyc();
    host_rd = 0; host_bg_mode = 0;
  endtask

  task automatic resume();
    host_bg_mode = 1; host_resume = 1;
    cyc();
    host_resume = 0; host_bg_mode = 0;
  endtask

  initial begin
    rst_n = 0;
    idle();
    cpu_user_run = 0; fetch_addr = 0; dmem_addr = 0; reg_acc_id = 0;
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();

    // R1 reset state
    for (int a = 0; a < 6; a++) hread(a, 16'hFFFF, 1, "R1 breakpoint reset value");
    hread(6, 0, 1, "R1 control reset value");
    hread(7, 0, 1, "R1 status reset value");
    chk("R1 dbg_mode after reset", int'(dbg_mode), 0);

    // R3 write outside background mode ignored; R2 read gated
    hwrite(0, 16'h0010, 0);
    hread(0, 16'hFFFF, 1, "R3 write without background ignored");
    hread(0, 0, 0, "R2 read without background returns zero");

    // program values
    hwrite(0, 16'h0100, 1); hwrite(1, 16'h0200, 1);
    hwrite(2, 16'h0300, 1); hwrite(3, 16'h0400, 1);
    hwrite(4, 16'h1234, 1); hwrite(5, 16'h0055, 1);
    hwrite(6, 1, 1);
    hread(2, 16'h0300, 1, "R2 breakpoint 2 read back");
    hread(6, 1, 1, "R2 control read back");
    hwrite(7, 16'h003F, 1);
    hread(7, 0, 1, "R2 status is read-only");

    cpu_user_run = 1;
    // R10 strobes low
    fetch_addr = 16'h0200; dmem_addr = 16'h1234; reg_acc_id = 16'h0055;
    cyc();
    chk("R10 no break with strobes low", int'(break_pulse), 0);

    // R4 fetch match on breakpoint 2
    fetch_addr = 16'h0300; fetch_vld = 1;
    cyc();
    fetch_vld = 0;
    chk("R4 fetch match pulse", int'(break_pulse), 1);
    chk("R4 status bit 2", int'(brk_status), 6'b000100);
    cyc();
    chk("R7 pulse one cycle", int'(break_pulse), 0);
    chk("R7 debug mode held", int'(dbg_mode), 1);
    fetch_vld = 1; fetch_addr = 16'h0100;
    cyc();
    fetch_vld = 0;
    chk("R8 no break in debug mode", int'(break_pulse), 0);
    chk("R8 status unchanged in debug", int'(brk_status), 6'b000100);
    resume();
    chk("R8 resume clears debug mode", int'(dbg_mode), 0);
    chk("R8 resume clears status", int'(brk_status), 0);

    // R5 data address on breakpoint 4
    dmem_addr = 16'h1234; dmem_wr = 1;
    cyc();
    dmem_wr = 0;
    chk("R5 data write match", int'(brk_status), 6'b010000);
    resume();

    // R5 breakpoint 5 in register-id mode
    hwrite(6, 5, 1);
    dmem_addr = 16'h0055; dmem_rd = 1;
    cyc();
    dmem_rd = 0;
    chk("R5 data access ignored in register mode", int'(break_pulse), 0);
    reg_acc_id = 16'h0055; reg_acc_vld = 1;
    cyc();
    reg_acc_vld = 0;
    chk("R5 register id match", int'(brk_status), 6'b100000);
    resume();

    // R9 simultaneous hits
    fetch_addr = 16'h0100; fetch_vld = 1; dmem_addr = 16'h1234; dmem_rd = 1;
    cyc();
    fetch_vld = 0; dmem_rd = 0;
    chk("R9 two breakpoints in one cycle", int'(brk_status), 6'b010001);
    chk("R9 single pulse", int'(break_pulse), 1);
    resume();

    // R6 gating by run state and arming
    cpu_user_run = 0; fetch_addr = 16'h0400; fetch_vld = 1;
    cyc();
    chk("R6 no break when not running user code", int'(break_pulse), 0);
    fetch_vld = 0; cpu_user_run = 1;
    hwrite(6, 0, 1);
    fetch_vld = 1;
    cyc();
    fetch_vld = 0;
    chk("R6 no break when disarmed", int'(break_pulse), 0);

    // random phase against model
    for (int n = 0; n < 3000; n++) begin
      int pool [4];
      pool[0] = 16'h0100; pool[1] = 16'h0300; pool[2] = 16'h1234; pool[3] = 16'h0055;
      idle();
      cpu_user_run = ($urandom_range(0, 7) != 0);
      fetch_vld   = $urandom_range(0, 1);
      fetch_addr  = 16'(pool[$urandom_range(0, 3)]);
      dmem_rd     = ($urandom_range(0, 3) == 0);
      dmem_wr     = ($urandom_range(0, 3) == 0);
      dmem_addr   = 16'(pool[$urandom_range(0, 3)]);
      reg_acc_vld = $urandom_range(0, 1);
      reg_acc_id  = 16'(pool[$urandom_range(0, 3)]);
      host_bg_mode = ($urandom_range(0, 1) == 0);
      host_resume  = ($urandom_range(0, 3) == 0);
      host_rd      = $urandom_range(0, 1);
      host_wr      = ($urandom_range(0, 7) == 0);
      host_addr    = 3'($urandom_range(0, 7));
      host_wdata   = (host_addr == 6) ? 16'($urandom_range(0, 7) | 1)
                                      : 16'(pool[$urandom_range(0, 3)]);
      cyc();
    end
    idle();
    cyc();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule